// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte stream into host memory. The host lays out a ring of descriptors. Each descriptor names a data buffer, gives the buffer's size and carries an ownership bit. The block claims the descriptor at its current ring position when a frame begins. It then streams the bytes into that buffer, moving on to following descriptors when a buffer fills. Each descriptor it finishes gets a message length and a status byte, and clearing the ownership bit hands it back. The host recycles a descriptor by writing the ownership bit to one again.

Configuration comes from two 16-bit words. One holds the low half of the ring's byte address. The other holds a 3-bit ring-size exponent in bits 15:13 and the upper address byte in bits 7:0. Memory is reached through a synchronous 16-bit port with byte enables. Read data appears on the cycle after the request. The stream side uses a valid/ready handshake with start, end and a 3-bit error code that is sampled with the final byte. The stream carries the frame check sequence bytes, and the block counts them like any other byte.

Top module: `rx_ring_writer`

## Requirements
- R1: During and after reset, with no stream activity, `mem_req`, `rint_pulse`, `miss_pulse` and `rx_ready` are all low.
- R2: Descriptor n sits at byte address {ring_cfg[7:0], ring_lo} + 8·n. Within it, the 16-bit words are: buffer address low (+0), {status byte, buffer address high byte} (+2), buffer-length (+4) and message-length (+6). The ring position advances modulo 2^ring_cfg[15:13].
- R3: Frame bytes are written to consecutive byte addresses from the buffer base, one byte per write. An even byte address uses lane 0 (`mem_be`=01) and an odd one uses lane 1 (`mem_be`=10).
- R4: Buffer size is the two's-complement negation of the buffer-length word, taken over its low 12 bits. A result of 0 means 4096.
- R5: Every finished descriptor gets message-length = the count of frame bytes accepted so far in that frame, in bits 11:0, with bits 15:12 zero.
- R6: The status byte is written last for each descriptor, through lane 1 only, so the address high byte is preserved. Its bits are: bit 7 owner (1 = block, written 0), bit 6 error summary, bit 5 framing, bit 4 overflow, bit 3 CRC, bit 2 buffer error, bit 1 first-of-frame, bit 0 last-of-frame.
- R7: A frame larger than one buffer continues into the next ring entry. Only the first descriptor of the frame has bit 1 set, and only the last has bit 0 set. A frame that ends exactly at a buffer boundary uses no further descriptor.
- R8: The stream error code (bit 2 framing, bit 1 overflow, bit 0 CRC), sampled with the end byte, is copied to status bits 5:3 of the last descriptor only. Bit 6 is set whenever any of bits 5:2 is set.
- R9: If the descriptor at the ring position is host-owned when a frame starts, the whole frame is consumed and discarded. `miss_pulse` is high for one cycle, no memory write occurs, and the ring position is unchanged.
- R10: If a buffer fills and the next descriptor is host-owned, the current descriptor closes with bits 6, 2 and 0 set. The rest of the frame is discarded, and the ring position stays at the host-owned entry.
- R11: `rint_pulse` is high for exactly one cycle after each frame's final status write, and never together with `miss_pulse`.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_lo | input | 16 | Ring byte address, low half |
| ring_cfg | input | 16 | Ring size exponent [15:13], ring address high byte [7:0] |
| rx_valid | input | 1 | Stream byte present |
| rx_ready | output | 1 | Stream byte accepted this cycle |
| rx_data | input | 8 | Stream byte |
| rx_sop | input | 1 | First byte of a frame |
| rx_eop | input | 1 | Last byte of a frame |
| rx_err | input | 3 | Frame error code, valid with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 23 | Memory word address |
| mem_be | output | 2 | Byte-lane enables for writes |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after a read request |
| rint_pulse | output | 1 | Frame delivered |
| miss_pulse | output | 1 | Frame dropped for lack of a descriptor |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 3-bit size exponent and the variant in which a buffer error also closes the frame. The ring-size field is set to 4 entries, so a short run of frames wraps the ring, both within one frame and between frames. Buffers of 16, 5 and 1 bytes make chaining reachable, as are exact boundary fits and odd buffer bases that exercise both byte lanes. After each frame the entire memory image is compared with the model's, so stray writes are caught as well as wrong ones.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   // width of a length field in a descriptor
   localparam int LEN_W = 12;

   // status byte bit positions (the host decodes these)
   localparam int ST_OWNER = 7;
   localparam int ST_ANYERR = 6;
   localparam int ST_FRAME = 5;
   localparam int ST_OVER = 4;
   localparam int ST_CRC = 3;
   localparam int ST_NOBUF = 2;
   localparam int ST_FIRST = 1;
   localparam int ST_LAST = 0;

   // descriptor word selectors
   localparam logic [1:0] DW_ADDR = 2'd0;
   localparam logic [1:0] DW_STAT = 2'd1;
   localparam logic [1:0] DW_BLEN = 2'd2;
   localparam logic [1:0] DW_MLEN = 2'd3;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_ADDR,
      S_RD_STAT,
      S_RD_BLEN,
      S_DECIDE,
      S_DATA,
      S_PUT_LEN,
      S_PUT_STAT,
      S_DROP
   } wr_state_e;
endpackage

// File: rtl/rxr_ring_step.sv
module rxr_ring_step #(
   parameter int LOG2_W = 3,
   parameter int IDX_W  = 7
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [LOG2_W-1:0] log2,
   output logic [IDX_W-1:0]  idx_inc
);
   logic [IDX_W-1:0] mask;

   always_comb begin
      mask    = (IDX_W'(1) << log2) - IDX_W'(1);
      idx_inc = (idx + IDX_W'(1)) & mask;
   end
endmodule

// File: rtl/rxr_desc_addr.sv
module rxr_desc_addr #(
   parameter int ADDR_W = 24,
   parameter int IDX_W  = 7
) (
   input  logic [ADDR_W-17:0] ring_hi,
   input  logic [15:0]        ring_lo,
   input  logic [IDX_W-1:0]   idx,
   input  logic [1:0]         word,
   output logic [ADDR_W-2:0]  waddr
);
   logic [ADDR_W-1:0] byte_addr;
   logic              unused_lsb;

   always_comb begin
      byte_addr = {ring_hi, ring_lo} + (ADDR_W'(idx) << 3) + ADDR_W'({word, 1'b0});
      waddr     = byte_addr[ADDR_W-1:1];
   end

   assign unused_lsb = byte_addr[0];
endmodule

// File: rtl/rxr_flag_pack.sv
module rxr_flag_pack
   import rxr_pkg::*;
#(
   parameter bit NOBUF_CLOSES = 1'b1
) (
   input  logic       first,
   input  logic       eop_end,
   input  logic       nobuf_end,
   input  logic [2:0] err,
   output logic [7:0] status
);
   logic last_bit;

   generate
      if (NOBUF_CLOSES) begin : g_nobuf_last
         assign last_bit = eop_end | nobuf_end;
      end else begin : g_nobuf_open
         assign last_bit = eop_end;
      end
   endgenerate

   always_comb begin
      status            = '0;
      status[ST_OWNER]  = 1'b0;
      status[ST_ANYERR] = (|err) | nobuf_end;
      status[ST_FRAME]  = err[2];
      status[ST_OVER]   = err[1];
      status[ST_CRC]    = err[0];
      status[ST_NOBUF]  = nobuf_end;
      status[ST_FIRST]  = first;
      status[ST_LAST]   = last_bit;
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rxr_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int LOG2_W       = 3,
   parameter bit NOBUF_CLOSES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       ring_lo,
   input  logic [15:0]       ring_cfg,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [7:0]        rx_data,
   input  logic              rx_sop,
   input  logic              rx_eop,
   input  logic [2:0]        rx_err,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-2:0] mem_addr,
   output logic [1:0]        mem_be,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   output logic              rint_pulse,
   output logic              miss_pulse
);
   localparam int IDX_W = (1 << LOG2_W) - 1;
   localparam int HI_W  = ADDR_W - 16;
   localparam int CNT_W = LEN_W + 1;

   generate
      if (ADDR_W < 17 || ADDR_W > 24) begin : g_bad_addr
         $error("rx_ring_writer: ADDR_W must lie in 17..24");
      end
      if (LOG2_W < 1 || LOG2_W > 3) begin : g_bad_log2
         $error("rx_ring_writer: LOG2_W must lie in 1..3");
      end
   endgenerate

   wr_state_e         state;
   logic              chaining;
   logic [15:0]       f_lo;
   logic [HI_W-1:0]   f_hi;
   logic              f_own;
   logic [CNT_W-1:0]  f_size;
   logic [ADDR_W-1:0] cur_base;
   logic [CNT_W-1:0]  cur_size;
   logic [CNT_W-1:0]  buf_cnt;
   logic [LEN_W-1:0]  frm_cnt;
   logic              cur_first;
   logic              end_eop;
   logic              end_nobuf;
   logic [2:0]        err_lat;
   logic [IDX_W-1:0]  cur_idx;
   logic [IDX_W-1:0]  nxt_idx;
   logic [IDX_W-1:0]  nxt_inc;

   logic [LOG2_W-1:0] ring_log2;
   logic [IDX_W-1:0]  sel_idx;
   logic [1:0]        sel_word;
   logic [ADDR_W-2:0] desc_waddr;
   logic [ADDR_W-1:0] data_addr;
   logic              use_data;
   logic [7:0]        status;
   logic [15:0]       neg_len;
   logic [CNT_W-1:0]  size_now;
   logic              unused_bits;

   assign ring_log2 = ring_cfg[15 -: LOG2_W];

   rxr_ring_step #(.LOG2_W(LOG2_W), .IDX_W(IDX_W)) u_step (
      .idx     (nxt_idx),
      .log2    (ring_log2),
      .idx_inc (nxt_inc)
   );

   rxr_desc_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_daddr (
      .ring_hi (ring_cfg[HI_W-1:0]),
      .ring_lo (ring_lo),
      .idx     (sel_idx),
      .word    (sel_word),
      .waddr   (desc_waddr)
   );

   rxr_flag_pack #(.NOBUF_CLOSES(NOBUF_CLOSES)) u_flags (
      .first     (cur_first),
      .eop_end   (end_eop),
      .nobuf_end (end_nobuf),
      .err       (err_lat),
      .status    (status)
   );

   // buffer size from the negated length word, 0 meaning the full 4096
   always_comb begin
      neg_len  = ~mem_rdata + 16'd1;
      size_now = {(neg_len[LEN_W-1:0] == '0), neg_len[LEN_W-1:0]};
   end

   assign data_addr = cur_base + ADDR_W'(buf_cnt);

   always_comb begin
      rx_ready  = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_be    = 2'b11;
      mem_wdata = '0;
      sel_idx   = nxt_idx;
      sel_word  = DW_ADDR;
      use_data  = 1'b0;
      case (state)
         S_IDLE: begin
            // stray bytes outside a frame are taken and discarded
            rx_ready = rx_valid & ~rx_sop;
         end
         S_RD_ADDR: begin
            mem_req  = 1'b1;
            sel_word = DW_ADDR;
         end
         S_RD_STAT: begin
            mem_req  = 1'b1;
            sel_word = DW_STAT;
         end
         S_RD_BLEN: begin
            mem_req  = 1'b1;
            sel_word = DW_BLEN;
         end
         S_DATA: begin
            rx_ready = 1'b1;
            use_data = 1'b1;
            if (rx_valid) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_be    = data_addr[0] ? 2'b10 : 2'b01;
               mem_wdata = {rx_data, rx_data};
            end
         end
         S_PUT_LEN: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            sel_idx   = cur_idx;
            sel_word  = DW_MLEN;
            mem_wdata = {{(16 - LEN_W){1'b0}}, frm_cnt};
         end
         S_PUT_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_be    = 2'b10;
            sel_idx   = cur_idx;
            sel_word  = DW_STAT;
            mem_wdata = {status, 8'h00};
         end
         S_DROP: begin
            rx_ready = 1'b1;
         end
         default: ;
      endcase
   end

   assign mem_addr = use_data ? data_addr[ADDR_W-1:1] : desc_waddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         chaining   <= 1'b0;
         f_lo       <= '0;
         f_hi       <= '0;
         f_own      <= 1'b0;
         f_size     <= '0;
         cur_base   <= '0;
         cur_size   <= '0;
         buf_cnt    <= '0;
         frm_cnt    <= '0;
         cur_first  <= 1'b0;
         end_eop    <= 1'b0;
         end_nobuf  <= 1'b0;
         err_lat    <= '0;
         cur_idx    <= '0;
         nxt_idx    <= '0;
         rint_pulse <= 1'b0;
         miss_pulse <= 1'b0;
      end else begin
         rint_pulse <= 1'b0;
         miss_pulse <= 1'b0;
         case (state)
            S_IDLE: begin
               if (rx_valid && rx_sop) begin
                  chaining  <= 1'b0;
                  end_eop   <= 1'b0;
                  end_nobuf <= 1'b0;
                  err_lat   <= '0;
                  state     <= S_RD_ADDR;
               end
            end
            S_RD_ADDR: state <= S_RD_STAT;
            S_RD_STAT: begin
               f_lo  <= mem_rdata;
               state <= S_RD_BLEN;
            end
            S_RD_BLEN: begin
               f_hi  <= mem_rdata[HI_W-1:0];
               f_own <= mem_rdata[15];
               state <= S_DECIDE;
            end
            S_DECIDE: begin
               f_size <= size_now;
               if (!chaining) begin
                  if (f_own) begin
                     cur_base  <= {f_hi, f_lo};
                     cur_size  <= size_now;
                     buf_cnt   <= '0;
                     frm_cnt   <= '0;
                     cur_first <= 1'b1;
                     cur_idx   <= nxt_idx;
                     nxt_idx   <= nxt_inc;
                     state     <= S_DATA;
                  end else begin
                     miss_pulse <= 1'b1;
                     state      <= S_DROP;
                  end
               end else begin
                  end_nobuf <= ~f_own;
                  state     <= S_PUT_LEN;
               end
            end
            S_DATA: begin
               if (rx_valid) begin
                  buf_cnt <= buf_cnt + CNT_W'(1);
                  frm_cnt <= frm_cnt + LEN_W'(1);
                  if (rx_eop) begin
                     end_eop <= 1'b1;
                     err_lat <= rx_err;
                     state   <= S_PUT_LEN;
                  end else if (buf_cnt + CNT_W'(1) == cur_size) begin
                     chaining <= 1'b1;
                     state    <= S_RD_ADDR;
                  end
               end
            end
            S_PUT_LEN: state <= S_PUT_STAT;
            S_PUT_STAT: begin
               if (end_eop) begin
                  rint_pulse <= 1'b1;
                  state      <= S_IDLE;
               end else if (end_nobuf) begin
                  rint_pulse <= 1'b1;
                  state      <= S_DROP;
               end else begin
                  cur_base  <= {f_hi, f_lo};
                  cur_size  <= f_size;
                  buf_cnt   <= '0;
                  cur_first <= 1'b0;
                  cur_idx   <= nxt_idx;
                  nxt_idx   <= nxt_inc;
                  state     <= S_DATA;
               end
            end
            S_DROP: begin
               if (rx_valid && rx_eop) state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign unused_bits = ^{mem_rdata[14:HI_W], neg_len[15:LEN_W], ring_cfg[15-LOG2_W:HI_W]};
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mem_req,
   input logic       mem_we,
   input logic [1:0] mem_be,
   input logic       rint_pulse,
   input logic       miss_pulse
);
   // R11: the two event pulses never coincide
   p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rint_pulse && miss_pulse));

   // R11: delivery pulse lasts one cycle
   p_rint_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rint_pulse |=> !rint_pulse);

   // R9: missed-frame pulse lasts one cycle
   p_miss_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |=> !miss_pulse);

   // R6: delivery is signalled right after a lane-1-only status write
   p_rint_after_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rint_pulse) |-> $past(mem_req && mem_we && mem_be == 2'b10));

   // R9: a miss comes with no write in the same cycle
   p_miss_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |-> !(mem_req && mem_we));
endmodule

bind rx_ring_writer rx_ring_writer_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_be     (mem_be),
   .rint_pulse (rint_pulse),
   .miss_pulse (miss_pulse)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
   localparam int RING = 32'h011000;
   localparam int LOGN = 2;
   localparam int MASK = (1 << LOGN) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ring_lo = 16'h1000;
   logic [15:0] ring_cfg = {3'(LOGN), 5'd0, 8'h01};
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [7:0]  rx_data = '0;
   logic        rx_sop = 1'b0;
   logic        rx_eop = 1'b0;
   logic [2:0]  rx_err = '0;
   logic        mem_req;
   logic        mem_we;
   logic [22:0] mem_addr;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        rint_pulse;
   logic        miss_pulse;

   int checks = 0;
   int fails = 0;
   int rint_seen = 0;
   int miss_seen = 0;
   int rint_exp = 0;
   int miss_exp = 0;
   int m_nxt = 0;

   logic [15:0] mem [int];
   logic [15:0] exp_mem [int];

   always #4 clk = ~clk;

   rx_ring_writer i_rx_ring_writer (
      .clk(clk), .rst_n(rst_n), .ring_lo(ring_lo), .ring_cfg(ring_cfg),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rint_pulse(rint_pulse), .miss_pulse(miss_pulse)
   );

   // synchronous memory, read data one cycle after the request
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            logic [15:0] w;
            w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
            if (mem_be[0]) w[7:0] = mem_wdata[7:0];
            if (mem_be[1]) w[15:8] = mem_wdata[15:8];
            mem[int'(mem_addr)] = w;
         end else begin
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && rint_pulse) rint_seen++;
      if (rst_n && miss_pulse) miss_seen++;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic logic [15:0] rdw(input int byte_addr);
      return exp_mem.exists(byte_addr >> 1) ? exp_mem[byte_addr >> 1] : 16'h0000;
   endfunction

   task automatic wrw(input int byte_addr, input logic [15:0] w);
      exp_mem[byte_addr >> 1] = w;
   endtask

   task automatic wrb(input int byte_addr, input logic [7:0] b);
      logic [15:0] w;
      w = rdw(byte_addr);
      if (byte_addr[0]) w[15:8] = b; else w[7:0] = b;
      wrw(byte_addr, w);
   endtask

   function automatic logic [7:0] byte_of(input int seed, input int k);
      return 8'((seed * 13 + k * 7 + 1) & 255);
   endfunction

   // host hands a descriptor to the block (written to both images)
   task automatic give(input int idx, input int base, input int size);
      int d;
      logic [15:0] blen;
      d = RING + 8 * idx;
      blen = 16'(-size) | 16'hF000;
      wrw(d, 16'(base));
      wrw(d + 2, {8'h80, 8'(base >> 16)});
      wrw(d + 4, blen);
      wrw(d + 6, 16'h0000);
      for (int i = 0; i < 4; i++) mem[(d >> 1) + i] = exp_mem[(d >> 1) + i];
   endtask

   task automatic close_desc(input int d, input logic [7:0] st, input int total);
      logic [15:0] w;
      wrw(d + 6, 16'(total & 12'hFFF));
      w = rdw(d + 2);
      wrw(d + 2, {st, w[7:0]});
   endtask

   // behavioural model of one frame over the expected memory image
   task automatic model(input int n, input int seed, input logic [2:0] err);
      int idx, k, first, total;
      idx = m_nxt; k = 0; first = 1; total = 0;
      if (!rdw(RING + 8 * idx + 2)[15]) begin
         miss_exp++;
         return;
      end
      forever begin
         int d, base, sz, off, nidx;
         logic [15:0] neg;
         d = RING + 8 * idx;
         base = {rdw(d + 2)[7:0], rdw(d)};
         neg = -rdw(d + 4);
         sz = neg[11:0];
         if (sz == 0) sz = 4096;
         off = 0;
         while (off < sz && k < n) begin
            wrb(base + off, byte_of(seed, k));
            off++; k++; total++;
         end
         if (k == n) begin
            close_desc(d, {1'b0, |err, err, 1'b0, first[0], 1'b1}, total);
            rint_exp++;
            m_nxt = (idx + 1) & MASK;
            break;
         end
         nidx = (idx + 1) & MASK;
         if (rdw(RING + 8 * nidx + 2)[15]) begin
            close_desc(d, {6'b0, first[0], 1'b0}, total);
            idx = nidx;
            first = 0;
         end else begin
            close_desc(d, {1'b0, 1'b1, 3'b000, 1'b1, first[0], 1'b1}, total);
            rint_exp++;
            m_nxt = nidx;
            break;
         end
      end
   endtask

   task automatic send(input int n, input int seed, input logic [2:0] err);
      int k;
      bit took;
      k = 0; took = 0;
      while (k < n) begin
         @(negedge clk);
         if (took) k++;
         took = 0;
         if (k < n) begin
            rx_valid = 1'b1;
            rx_data = byte_of(seed, k);
            rx_sop = (k == 0);
            rx_eop = (k == n - 1);
            rx_err = (k == n - 1) ? err : 3'b000;
            #1;
            took = rx_ready;
         end
      end
      rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = '0;
   endtask

   task automatic frame(input int n, input int seed, input logic [2:0] err,
                        input string tag);
      int bad, first_key;
      model(n, seed, err);
      send(n, seed, err);
      repeat (20) @(negedge clk);
      bad = 0; first_key = -1;
      foreach (exp_mem[key])
         if (!mem.exists(key) || mem[key] !== exp_mem[key]) begin
            bad++;
            if (first_key < 0) first_key = key;
         end
      foreach (mem[key])
         if (!exp_mem.exists(key)) begin
            bad++;
            if (first_key < 0) first_key = key;
         end
      if (bad != 0)
         chk(1'b0, tag, "memory word (byte addr)",
             mem.exists(first_key) ? int'(mem[first_key]) : -1,
             exp_mem.exists(first_key) ? int'(exp_mem[first_key]) : -1);
      else
         chk(1'b1, tag, "memory image", 0, 0);
      chk(rint_seen == rint_exp, "R11", "delivery pulse count", rint_seen, rint_exp);
      chk(miss_seen == miss_exp, "R9", "missed pulse count", miss_seen, miss_exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
      chk(rx_ready == 1'b0, "R1", "rx_ready in reset", rx_ready, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rint_pulse == 1'b0 && miss_pulse == 1'b0, "R1", "pulses after reset",
          {rint_pulse, miss_pulse}, 0);
      chk(mem_req == 1'b0, "R1", "mem_req idle", mem_req, 0);

      give(0, 32'h020000, 16);
      give(1, 32'h020100, 16);
      give(2, 32'h020200, 16);
      give(3, 32'h020300, 16);

      frame(10, 1, 3'b000, "R3");      // single buffer, R2 R5 R6
      frame(16, 2, 3'b000, "R7");      // exact fit, no extra descriptor
      frame(20, 3, 3'b001, "R8");      // chained, CRC on last only, R4
      frame(8, 4, 3'b000, "R9");       // entry 0 host-owned: dropped
      give(0, 32'h020400, 16);
      give(1, 32'h020500, 16);
      frame(40, 5, 3'b010, "R10");     // runs into host-owned entry 2
      give(2, 32'h020601, 5);
      give(3, 32'h030700, 16);
      give(0, 32'h020800, 16);
      frame(5, 6, 3'b110, "R3");       // odd base, lane 1 first, R8
      frame(25, 7, 3'b000, "R2");      // chain across the ring wrap
      frame(1, 8, 3'b000, "R9");       // entry 1 still host-owned
      give(1, 32'h020900, 1);
      frame(1, 9, 3'b100, "R4");       // one-byte buffer, start and end together

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule